// File: doc/BRIEF.md
# Tone Guard-Time Steering and Code Latch

This block replaces an analogue RC steering network behind a dual-tone classifier. The classifier supplies an early detect flag and a candidate 4-bit key code. The block times how long the flag stays high, using a programmable tone-present guard counted in ticks of a 1 ms clock enable. When the guard is met, the block loads the candidate code into an output latch. Two clock cycles later it raises a delayed steering strobe. The strobe falls only after the flag has stayed low for a second programmable guard, the tone-absent time. Drop-outs shorter than that guard are therefore ignored, and the latched code stays put.

The total recognition time is the upstream detection delay plus the present guard. Choose the guard so that tones of 40 ms or longer are accepted and tones of 20 ms or shorter are rejected. The latched code is always presented on `codeOut`. The output-enable input is passed through as a pad enable, and the pad ring turns the pair into a three-state bus. That pad is expected to carry a pull-up so that an open enable selects drive.

Top module: `tone_steer_latch`

## Requirements
- R1: While `rst` is high at a rising clock edge, the latch clears to 4'b0000, `strobe` goes low and both guard timers clear. Any tone in progress must then be timed again from its start.
- R2: A code is loaded only when `earlyFlag` stays high through `presentGuard` ticks that are sampled after the rising edge of the flag. A burst that covers fewer ticks leaves `codeOut` and `strobe` unchanged.
- R3: A guard value of 0 behaves as a guard of 1 tick, for both the present and the absent guard.
- R4: On a first registration, `codeOut` takes the new code at the clock edge of the completing tick, and `strobe` rises exactly 2 clock cycles later. The data is therefore stable for 2 cycles before the strobe rises.
- R5: Once high, `strobe` falls at the clock edge of the `absentGuard`-th tick with `earlyFlag` continuously low. A shorter low interval leaves `strobe` high.
- R6: `codeOut` keeps the last registered code through pauses, drop-outs and strobe release, until a new registration occurs.
- R7: If `earlyFlag` returns while the absent guard is still running, that timer restarts from zero and `strobe` stays high. A code is loaded in that state only after a full present guard, and when it loads, `strobe` stays high.
- R8: `codeOe` equals `outEn` in the same cycle (1 means drive, 0 means high impedance). The latch keeps loading, and `codeOut` keeps showing it, while `outEn` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-cycle 1 ms time-base enable |
| earlyFlag | input | 1 | Early detect flag from the tone classifier |
| candCode | input | 4 | Candidate key code from the classifier |
| presentGuard | input | 8 | Tone-present guard, in ticks |
| absentGuard | input | 8 | Tone-absent guard, in ticks |
| outEn | input | 1 | Bus drive request (pad carries a pull-up) |
| codeOut | output | 4 | Latched key code, toward the pad |
| codeOe | output | 1 | Pad drive enable for codeOut |
| strobe | output | 1 | Delayed steering strobe |

## Verification
A code load is visible just after the clock edge of the tick that completes the present guard. The strobe rises 2 edges after that load and falls at the edge of the tick that completes the absent guard. `codeOe` follows `outEn` within the same cycle. The bench places ticks on phase 0 and flag changes on phase 2 of a 4-cycle frame, so every guard boundary lands on a known edge. A tick-level reference model, evaluated on each rising edge, is compared against the outputs at the following falling edge. Directed probes stop exactly one tick short of each guard and then on it.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
  typedef struct packed {
    logic loadCode;
    logic setStrobe;
    logic clrStrobe;
  } steerCmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRES, ST_SETUP, ST_HELD, ST_ABS, ST_RETRY
  } steerState_t;
endpackage

// File: rtl/steer_ctrl.sv
`timescale 1ns/1ps
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int GUARD_W   = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               earlyFlag,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  output steerCmd_t          cmd
);
  localparam int SW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC + 1);
  localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CYC - 1);

  steerState_t        state;
  logic [GUARD_W-1:0] tickCnt;
  logic [SW-1:0]      setupCnt;
  logic               presentHit, absentHit, countingPresent;

  // a guard of zero collapses onto one tick
  assign presentHit = ({1'b0, tickCnt} + 1'b1) >= {1'b0, presentGuard};
  assign absentHit  = ({1'b0, tickCnt} + 1'b1) >= {1'b0, absentGuard};
  assign countingPresent = (state == ST_PRES) || (state == ST_RETRY);

  always_comb begin
    cmd.loadCode  = countingPresent && earlyFlag && tickEn && presentHit;
    cmd.setStrobe = (state == ST_SETUP) && (setupCnt == SETUP_LAST);
    cmd.clrStrobe = (state == ST_ABS) && !earlyFlag && tickEn && absentHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      setupCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (earlyFlag) begin
          state   <= ST_PRES;
          tickCnt <= '0;
        end
        ST_PRES: begin
          if (!earlyFlag) state <= ST_IDLE;
          else if (tickEn) begin
            if (cmd.loadCode) begin
              state    <= ST_SETUP;
              setupCnt <= '0;
            end else tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_SETUP: begin
          if (cmd.setStrobe) state <= ST_HELD;
          else setupCnt <= setupCnt + 1'b1;
        end
        ST_HELD: if (!earlyFlag) begin
          state   <= ST_ABS;
          tickCnt <= '0;
        end
        ST_ABS: begin
          if (earlyFlag) begin
            state   <= ST_RETRY;
            tickCnt <= '0;
          end else if (tickEn) begin
            if (cmd.clrStrobe) state <= ST_IDLE;
            else tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_RETRY: begin
          if (!earlyFlag) begin
            state   <= ST_ABS;
            tickCnt <= '0;
          end else if (tickEn) begin
            if (cmd.loadCode) state <= ST_HELD;
            else tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  present_qual_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.loadCode |-> $past(earlyFlag));

  // R5
  absent_qual_chk: assert property (@(posedge clk) disable iff (rst)
    cmd.clrStrobe |-> !$past(earlyFlag));

  // R4
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd.loadCode, cmd.setStrobe, cmd.clrStrobe}));
endmodule

// File: rtl/steer_dpath.sv
`timescale 1ns/1ps
module steer_dpath
  import steer_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  steerCmd_t         cmd,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              outEn,
  output logic [CODE_W-1:0] codeOut,
  output logic              codeOe,
  output logic              strobe
);
  logic [CODE_W-1:0] latchQ;
  logic              strobeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      latchQ  <= '0;
      strobeQ <= 1'b0;
    end else begin
      if (cmd.loadCode)       latchQ  <= codeIn;
      if (cmd.setStrobe)      strobeQ <= 1'b1;
      else if (cmd.clrStrobe) strobeQ <= 1'b0;
    end
  end

  assign codeOut = latchQ;
  assign codeOe  = outEn;
  assign strobe  = strobeQ;

  // R4
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobeQ) |-> (!$past(cmd.loadCode) && $stable(latchQ)));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd.loadCode |=> $stable(latchQ));

  // R5
  strobe_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobeQ && !cmd.clrStrobe) |=> strobeQ);
endmodule

// File: rtl/tone_steer_latch.sv
`timescale 1ns/1ps
module tone_steer_latch
  import steer_pkg::*;
#(
  parameter int CODE_W    = 4,
  parameter int GUARD_W   = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               earlyFlag,
  input  logic [CODE_W-1:0]  candCode,
  input  logic [GUARD_W-1:0] presentGuard,
  input  logic [GUARD_W-1:0] absentGuard,
  input  logic               outEn,
  output logic [CODE_W-1:0]  codeOut,
  output logic               codeOe,
  output logic               strobe
);
  steerCmd_t cmd;

  steer_ctrl #(.GUARD_W(GUARD_W), .SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .earlyFlag(earlyFlag),
    .presentGuard(presentGuard), .absentGuard(absentGuard), .cmd(cmd)
  );

  steer_dpath #(.CODE_W(CODE_W)) u_dpath (
    .clk(clk), .rst(rst), .cmd(cmd), .codeIn(candCode), .outEn(outEn),
    .codeOut(codeOut), .codeOe(codeOe), .strobe(strobe)
  );
endmodule

// File: tb/tone_steer_latch_bench.sv
`timescale 1ns/1ps
module tone_steer_latch_bench;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b0;
  logic earlyFlag = 1'b0;
  logic [3:0] candCode = 4'h0;
  logic [7:0] presentGuard = 8'd3;
  logic [7:0] absentGuard = 8'd4;
  logic outEn = 1'b1;
  logic [3:0] codeOut;
  logic codeOe, strobe;

  always #(CLK_NS/2) clk = ~clk;

  tone_steer_latch u_tone_steer_latch (
    .clk(clk), .rst(rst), .tickEn(tickEn), .earlyFlag(earlyFlag),
    .candCode(candCode), .presentGuard(presentGuard), .absentGuard(absentGuard),
    .outEn(outEn), .codeOut(codeOut), .codeOe(codeOe), .strobe(strobe)
  );

  int total = 0, bad = 0, phase = 0;
  logic flagReq = 1'b0;
  logic [3:0] codeReq = 4'h0;
  // reference model state
  logic [3:0] mLatch = 4'h0;
  logic mStrobe = 1'b0, prevFlag = 1'b0, registered = 1'b0;
  int run = 0, gap = 0, setupLeft = 0;
  // observation history for the setup check
  logic [3:0] hist1 = 4'h0, hist2 = 4'h0;
  logic prevStrobeObs = 1'b0;

  function automatic int effG(input logic [7:0] g);
    return (g == 8'd0) ? 1 : int'(g);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    if (rst) begin
      mLatch = 4'h0; mStrobe = 1'b0; run = 0; gap = 0;
      setupLeft = 0; prevFlag = 1'b0; registered = 1'b0;
      return;
    end
    if (setupLeft > 0) begin
      setupLeft--;
      if (setupLeft == 0) mStrobe = 1'b1;
    end
    if (earlyFlag != prevFlag) begin
      run = 0; gap = 0; registered = 1'b0;
    end
    prevFlag = earlyFlag;
    if (tickEn) begin
      if (earlyFlag) begin
        run++;
        if (!registered && run >= effG(presentGuard)) begin
          mLatch = candCode;
          registered = 1'b1;
          if (!mStrobe && setupLeft == 0) setupLeft = 2;
        end
      end else begin
        gap++;
        if (mStrobe && gap == effG(absentGuard)) mStrobe = 1'b0;
      end
    end
  endtask

  task automatic checkOutputs();
    check(codeOut == mLatch, "R2/R6 codeOut", codeOut, mLatch);
    check(strobe == mStrobe, "R5/R7 strobe", strobe, mStrobe);
    check(codeOe == outEn, "R8 codeOe", codeOe, outEn);
    if (strobe && !prevStrobeObs && !rst)
      check(codeOut == hist1 && hist1 == hist2, "R4 setup", hist2, codeOut);
    hist2 = hist1; hist1 = codeOut; prevStrobeObs = strobe;
  endtask

  task automatic doCycle();
    tickEn = (phase == 0);
    if (phase == 2) earlyFlag = flagReq;
    candCode = codeReq;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    checkOutputs();
    phase = (phase + 1) % 4;
  endtask

  task automatic segment(input logic f, input int ticks, input logic [3:0] c);
    flagReq = f; codeReq = c;
    while (phase != 2) doCycle();
    repeat (ticks * 4) doCycle();
  endtask

  task automatic resetDut(input logic [7:0] pg, input logic [7:0] ag);
    rst = 1'b1; earlyFlag = 1'b0; flagReq = 1'b0;
    presentGuard = pg; absentGuard = ag;
    repeat (3) doCycle();
    check(codeOut == 4'h0, "R1 reset code", codeOut, 0);
    check(strobe == 1'b0, "R1 reset strobe", strobe, 0);
    rst = 1'b0;
    while (phase != 2) doCycle();
  endtask

  initial begin
    #(CLK_NS * 190000);
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    resetDut(8'd3, 8'd4);

    // R2: two ticks are one short of the guard
    segment(1'b1, 2, 4'h5);
    check(codeOut == 4'h0, "R2 short burst code", codeOut, 0);
    check(strobe == 1'b0, "R2 short burst strobe", strobe, 0);
    segment(1'b0, 3, 4'h5);
    // R4: load on third tick, strobe two edges later
    segment(1'b1, 3, 4'hA);
    check(codeOut == 4'hA, "R4 code loaded", codeOut, 4'hA);
    check(strobe == 1'b0, "R4 strobe not yet", strobe, 0);
    doCycle();
    check(strobe == 1'b1, "R4 strobe risen", strobe, 1);
    // R5: drop-out of three ticks is tolerated
    segment(1'b0, 3, 4'h2);
    check(strobe == 1'b1, "R5 dropout kept", strobe, 1);
    segment(1'b1, 1, 4'h3);
    check(codeOut == 4'hA, "R7 no early load", codeOut, 4'hA);
    segment(1'b0, 4, 4'h3);
    check(strobe == 1'b0, "R5 release", strobe, 0);
    check(codeOut == 4'hA, "R6 code held", codeOut, 4'hA);
    // R7: return during absent timing, full guard needed
    segment(1'b1, 3, 4'h6);
    doCycle();
    segment(1'b0, 2, 4'h9);
    segment(1'b1, 2, 4'h9);
    check(codeOut == 4'h6, "R7 before guard", codeOut, 4'h6);
    segment(1'b1, 1, 4'h9);
    check(codeOut == 4'h9, "R7 reload", codeOut, 4'h9);
    check(strobe == 1'b1, "R7 strobe held", strobe, 1);
    // R8: load while bus disabled
    segment(1'b0, 4, 4'h0);
    outEn = 1'b0;
    segment(1'b1, 3, 4'hC);
    check(codeOe == 1'b0, "R8 disabled", codeOe, 0);
    check(codeOut == 4'hC, "R8 latch updates", codeOut, 4'hC);
    outEn = 1'b1;
    segment(1'b0, 5, 4'h0);
    // R1: reset mid-tone restarts timing
    segment(1'b1, 2, 4'h7);
    resetDut(8'd3, 8'd2);
    segment(1'b1, 2, 4'h7);
    check(codeOut == 4'h0, "R1 timer cleared", codeOut, 0);
    segment(1'b0, 2, 4'h0);
    // R3: zero guards act as one tick
    resetDut(8'd0, 8'd0);
    segment(1'b1, 1, 4'hE);
    check(codeOut == 4'hE, "R3 zero present guard", codeOut, 4'hE);
    doCycle();
    segment(1'b0, 1, 4'h0);
    check(strobe == 1'b0, "R3 zero absent guard", strobe, 0);

    // random rounds against the model
    for (int rnd = 0; rnd < 4; rnd++) begin
      resetDut(8'($urandom_range(1, 6)), 8'($urandom_range(1, 6)));
      for (int s = 0; s < 40; s++) begin
        outEn = 1'($urandom_range(0, 3) != 0);
        segment(1'($urandom_range(0, 1)), $urandom_range(1, 8), 4'($urandom));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule